// File: doc/BRIEF.md
# Lossy Bufferless Mesh Router

This block is the router for one node of a two-dimensional mesh that carries only single-flit packets. It has four neighbour links (north, east, south, west), one injection port fed from the local node's send queue, and one ejection port. Each flit carries two signed hop counts (X and Y remaining to the destination) and a data word. The router chooses an output by dimension-order routing: X first, then Y. It settles conflicts with priorities that are wired in and keep no state. It moves the hop count one step toward zero, all within a single cycle.

Nothing is buffered. Each neighbour link has one register that holds one flit. A flit that loses arbitration is discarded without notice, because a companion lossless network is assumed to deliver every packet anyway. The injection port is told in the same cycle whether its flit won an output. The source can then hold the flit at the head of its queue and offer it again.

Top module: `lossy_mesh_router`

## Requirements
- R1: A flit on a neighbour link input is captured at a rising clock edge and is routed onto the outputs in the cycle after that edge. An injected flit is routed combinationally in the cycle it is presented.
- R2: Link vectors are indexed north=0, east=1, south=2, west=3. Positive X points east and positive Y points north. Routing works as follows:
  - X>0 goes to east and X<0 goes to west.
  - X=0 with Y>0 goes to north, and X=0 with Y<0 goes to south.
  - X=Y=0 goes to ejection.
- R3: A forwarded flit leaves with the count of the dimension it travels in moved one step toward zero. The other count and the data are unchanged.
- R4: The east output takes only a west-input flit, and failing that an injected flit. The west output takes only an east-input flit, and failing that an injected flit. The opposing input always wins.
- R5: The north output takes candidates in this order:
  - a south-input flit going straight;
  - a west-input flit turning;
  - an east-input flit turning;
  - the injected flit.
  The south output uses the same order with the north input in first place.
- R6: The ejection output takes flits whose X and Y are both zero, in the fixed order north, south, west, east. Only the data word is presented.
- R7: A flit that loses arbitration appears on no output, and it is not offered again in any later cycle.
- R8: `inj_accept` is high in exactly the cycles in which the injected flit wins an output. An injected flit with X=Y=0 is never accepted and never ejected.
- R9: Under synchronous active-low reset the link registers clear. With no injection, every output valid is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_in_vld | input | 4 | Valid per neighbour input (N,E,S,W) |
| link_in_dx | input | 4*COORD_W | Signed remaining X hops per input |
| link_in_dy | input | 4*COORD_W | Signed remaining Y hops per input |
| link_in_data | input | 4*DATA_W | Data word per input |
| inj_vld | input | 1 | Local flit offered for injection |
| inj_dx | input | COORD_W | Signed X hops of injected flit |
| inj_dy | input | COORD_W | Signed Y hops of injected flit |
| inj_data | input | DATA_W | Data of injected flit |
| inj_accept | output | 1 | Injected flit won an output this cycle |
| link_out_vld | output | 4 | Valid per neighbour output (N,E,S,W) |
| link_out_dx | output | 4*COORD_W | Updated X hops per output |
| link_out_dy | output | 4*COORD_W | Updated Y hops per output |
| link_out_data | output | 4*DATA_W | Data per output |
| ej_vld | output | 1 | Flit delivered to the local node |
| ej_data | output | DATA_W | Data of the ejected flit |

## Verification
Link inputs pass through exactly one register. A flit driven on a link in one cycle therefore shows up on the outputs in the next cycle. An injected flit affects the outputs and `inj_accept` in the cycle it is driven. The bench drives all inputs just after the falling edge and keeps its own copy of the previous cycle's link inputs, which stands for the registered state. Shortly after the drive it compares every output against an expected value built from that copy and the current injection. All comparisons are therefore made half a cycle away from the active edge.

// File: rtl/mesh_rtr_pkg.sv
// Shared constants and the fixed arbitration order for the lossy mesh router.
// Assumes cardinal indices N=0, E=1, S=2, W=3 and the injection source at 4.
package mesh_rtr_pkg;

    localparam int NUM_CARD  = 4;
    localparam int NUM_SRC   = NUM_CARD + 1;
    localparam int NUM_OUT   = NUM_CARD + 1;
    localparam int SRC_INJ   = NUM_CARD;
    localparam int OUT_EJ    = NUM_CARD;
    localparam int RANK_NONE = 7;

    localparam int DIR_N = 0;
    localparam int DIR_E = 1;
    localparam int DIR_S = 2;
    localparam int DIR_W = 3;

    // Source that holds a given rank (0 = highest) at a given output.
    function automatic int rank_src(input int out_idx, input int rank);
        int src;
        src = RANK_NONE;
        case (out_idx)
            DIR_N: case (rank)
                       0: src = DIR_S;
                       1: src = DIR_W;
                       2: src = DIR_E;
                       3: src = SRC_INJ;
                       default: src = RANK_NONE;
                   endcase
            DIR_S: case (rank)
                       0: src = DIR_N;
                       1: src = DIR_W;
                       2: src = DIR_E;
                       3: src = SRC_INJ;
                       default: src = RANK_NONE;
                   endcase
            DIR_E: case (rank)
                       0: src = DIR_W;
                       1: src = SRC_INJ;
                       default: src = RANK_NONE;
                   endcase
            DIR_W: case (rank)
                       0: src = DIR_E;
                       1: src = SRC_INJ;
                       default: src = RANK_NONE;
                   endcase
            OUT_EJ: case (rank)
                       0: src = DIR_N;
                       1: src = DIR_S;
                       2: src = DIR_W;
                       3: src = DIR_E;
                       default: src = RANK_NONE;
                   endcase
            default: src = RANK_NONE;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/mesh_flit_reg.sv
// One-flit holding register for a neighbour link input.
// Captures every cycle; the valid bit clears under synchronous active-low reset.
module mesh_flit_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_vld,
    input  logic [W-1:0] d_body,
    output logic         q_vld,
    output logic [W-1:0] q_body
);

    // Capture the incoming flit, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_body <= '0;
        end else begin
            q_vld  <= d_vld;
            q_body <= d_body;
        end
    end

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_vld == $past(d_vld)) && (q_body == $past(d_body)));

endmodule

// File: rtl/mesh_route_step.sv
// Dimension-order route decode for one source.
// Produces a one-hot output request (N,E,S,W,EJ) and the header with the travelled
// dimension stepped one toward zero. Assumes signed two's-complement hop counts.
module mesh_route_step
    import mesh_rtr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic               vld,
    input  logic [CW-1:0]      dx,
    input  logic [CW-1:0]      dy,
    output logic [NUM_OUT-1:0] req,
    output logic [CW-1:0]      nx_dx,
    output logic [CW-1:0]      nx_dy
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic x_pos, x_neg, y_pos, y_neg;

    // Sign classification of the remaining hop counts.
    always_comb begin
        x_pos = !dx[CW-1] && (dx != '0);
        x_neg = dx[CW-1];
        y_pos = !dy[CW-1] && (dy != '0);
        y_neg = dy[CW-1];
    end

    // X first, then Y, then ejection.
    always_comb begin
        req = '0;
        if (vld) begin
            if (x_pos)      req[DIR_E]  = 1'b1;
            else if (x_neg) req[DIR_W]  = 1'b1;
            else if (y_pos) req[DIR_N]  = 1'b1;
            else if (y_neg) req[DIR_S]  = 1'b1;
            else            req[OUT_EJ] = 1'b1;
        end
    end

    // Step the travelled dimension one hop toward zero.
    always_comb begin
        nx_dx = dx;
        nx_dy = dy;
        if (x_pos)      nx_dx = dx - ONE;
        else if (x_neg) nx_dx = dx + ONE;
        else if (y_pos) nx_dy = dy - ONE;
        else if (y_neg) nx_dy = dy + ONE;
    end

endmodule

// File: rtl/mesh_prio_pick.sv
// Fixed-priority pick: bit 0 is the highest rank. Stateless; output is one-hot or zero.
module mesh_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Grant the lowest-index request.
    always_comb begin
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
        end
    end

endmodule

// File: rtl/lossy_mesh_router.sv
// Single-cycle bufferless router for one node of a 2D mesh.
// Each neighbour input is held in one register; routing, fixed-priority arbitration
// and header stepping happen combinationally from those registers and the
// injection port. Losers are dropped. Assumes traffic follows XY order, so no
// flit ever needs to return toward the link it came from.
module lossy_mesh_router
    import mesh_rtr_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int DATA_W  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_CARD-1:0]                link_in_vld,
    input  logic [NUM_CARD-1:0][COORD_W-1:0]   link_in_dx,
    input  logic [NUM_CARD-1:0][COORD_W-1:0]   link_in_dy,
    input  logic [NUM_CARD-1:0][DATA_W-1:0]    link_in_data,
    input  logic                               inj_vld,
    input  logic [COORD_W-1:0]                 inj_dx,
    input  logic [COORD_W-1:0]                 inj_dy,
    input  logic [DATA_W-1:0]                  inj_data,
    output logic                               inj_accept,
    output logic [NUM_CARD-1:0]                link_out_vld,
    output logic [NUM_CARD-1:0][COORD_W-1:0]   link_out_dx,
    output logic [NUM_CARD-1:0][COORD_W-1:0]   link_out_dy,
    output logic [NUM_CARD-1:0][DATA_W-1:0]    link_out_data,
    output logic                               ej_vld,
    output logic [DATA_W-1:0]                  ej_data
);

    localparam int BODY_W = 2 * COORD_W + DATA_W;

    logic                src_vld  [NUM_SRC];
    logic [COORD_W-1:0]  src_dx   [NUM_SRC];
    logic [COORD_W-1:0]  src_dy   [NUM_SRC];
    logic [DATA_W-1:0]   src_data [NUM_SRC];
    logic [BODY_W-1:0]   held_body[NUM_CARD];

    logic [NUM_OUT-1:0]  req   [NUM_SRC];
    logic [COORD_W-1:0]  nx_dx [NUM_SRC];
    logic [COORD_W-1:0]  nx_dy [NUM_SRC];

    logic [NUM_SRC-1:0]  cand  [NUM_OUT];
    logic [NUM_SRC-1:0]  rgnt  [NUM_OUT];
    logic [NUM_SRC-1:0]  gnt   [NUM_OUT];
    logic [NUM_OUT-1:0]  col   [NUM_SRC];

    // One holding register per neighbour link.
    for (genvar c = 0; c < NUM_CARD; c++) begin : g_in
        mesh_flit_reg #(.W(BODY_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_vld  (link_in_vld[c]),
            .d_body ({link_in_dx[c], link_in_dy[c], link_in_data[c]}),
            .q_vld  (src_vld[c]),
            .q_body (held_body[c])
        );
        assign {src_dx[c], src_dy[c], src_data[c]} = held_body[c];
    end

    // The injection source is taken straight from the port.
    assign src_vld[SRC_INJ]  = inj_vld;
    assign src_dx[SRC_INJ]   = inj_dx;
    assign src_dy[SRC_INJ]   = inj_dy;
    assign src_data[SRC_INJ] = inj_data;

    // Route decode for every source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rt
        mesh_route_step #(.CW(COORD_W)) u_rt (
            .vld   (src_vld[s]),
            .dx    (src_dx[s]),
            .dy    (src_dy[s]),
            .req   (req[s]),
            .nx_dx (nx_dx[s]),
            .nx_dy (nx_dy[s])
        );
    end

    // Reorder each output's requests into its fixed rank order.
    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int r = 0; r < NUM_SRC; r++) begin
                int sidx;
                sidx = rank_src(o, r);
                if (sidx < NUM_SRC) cand[o][r] = req[sidx][o];
                else                cand[o][r] = 1'b0;
            end
        end
    end

    // One stateless priority pick per output.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_arb
        mesh_prio_pick #(.N(NUM_SRC)) u_pick (
            .req (cand[o]),
            .gnt (rgnt[o])
        );
    end

    // Map rank grants back to source grants.
    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            gnt[o] = '0;
            for (int r = 0; r < NUM_SRC; r++) begin
                int sidx;
                sidx = rank_src(o, r);
                if (sidx < NUM_SRC && rgnt[o][r]) gnt[o][sidx] = 1'b1;
            end
        end
    end

    // Output multiplexers driven by the source grants.
    always_comb begin
        for (int o = 0; o < NUM_CARD; o++) begin
            link_out_vld[o]  = |gnt[o];
            link_out_dx[o]   = '0;
            link_out_dy[o]   = '0;
            link_out_data[o] = '0;
            for (int s = 0; s < NUM_SRC; s++) begin
                link_out_dx[o]   = link_out_dx[o]   | ({COORD_W{gnt[o][s]}} & nx_dx[s]);
                link_out_dy[o]   = link_out_dy[o]   | ({COORD_W{gnt[o][s]}} & nx_dy[s]);
                link_out_data[o] = link_out_data[o] | ({DATA_W{gnt[o][s]}}  & src_data[s]);
            end
        end
        ej_vld  = |gnt[OUT_EJ];
        ej_data = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            ej_data = ej_data | ({DATA_W{gnt[OUT_EJ][s]}} & src_data[s]);
        end
    end

    // Per-source view of grants, used for acceptance and checking.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int o = 0; o < NUM_OUT; o++) col[s][o] = gnt[o][s];
        end
        inj_accept = |col[SRC_INJ];
    end

    // R7
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_once
        src_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[s]));
    end

    // R8
    inj_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_accept |-> inj_vld && ((inj_dx != '0) || (inj_dy != '0)));

    // R4
    east_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_out_vld[DIR_E] |-> (src_vld[DIR_W] || inj_vld));

    // R5
    north_straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vld[DIR_S] && src_dx[DIR_S] == '0 && !src_dy[DIR_S][COORD_W-1]
         && src_dy[DIR_S] != '0)
        |-> link_out_vld[DIR_N] && (link_out_data[DIR_N] == src_data[DIR_S]));

    // R6
    eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ej_vld |->
            (src_vld[DIR_N] && src_dx[DIR_N] == '0 && src_dy[DIR_N] == '0) ||
            (src_vld[DIR_S] && src_dx[DIR_S] == '0 && src_dy[DIR_S] == '0) ||
            (src_vld[DIR_W] && src_dx[DIR_W] == '0 && src_dy[DIR_W] == '0) ||
            (src_vld[DIR_E] && src_dx[DIR_E] == '0 && src_dy[DIR_E] == '0));

endmodule

// File: tb/tb_lossy_mesh_router.sv
`timescale 1ns/1ps
module tb_lossy_mesh_router;

    localparam int CW = 4;
    localparam int DW = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [3:0]            link_in_vld;
    logic [3:0][CW-1:0]    link_in_dx;
    logic [3:0][CW-1:0]    link_in_dy;
    logic [3:0][DW-1:0]    link_in_data;
    logic                  inj_vld;
    logic [CW-1:0]         inj_dx;
    logic [CW-1:0]         inj_dy;
    logic [DW-1:0]         inj_data;
    logic                  inj_accept;
    logic [3:0]            link_out_vld;
    logic [3:0][CW-1:0]    link_out_dx;
    logic [3:0][CW-1:0]    link_out_dy;
    logic [3:0][DW-1:0]    link_out_data;
    logic                  ej_vld;
    logic [DW-1:0]         ej_data;

    lossy_mesh_router #(.COORD_W(CW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .link_in_vld(link_in_vld), .link_in_dx(link_in_dx),
        .link_in_dy(link_in_dy), .link_in_data(link_in_data),
        .inj_vld(inj_vld), .inj_dx(inj_dx), .inj_dy(inj_dy), .inj_data(inj_data),
        .inj_accept(inj_accept),
        .link_out_vld(link_out_vld), .link_out_dx(link_out_dx),
        .link_out_dy(link_out_dy), .link_out_data(link_out_data),
        .ej_vld(ej_vld), .ej_data(ej_data)
    );

    always #2 clk = ~clk;

    // staged (n*), applied (d*), registered copy (s*)
    int nv[4], nx[4], ny[4], nd[4];
    int dv[4], ddx[4], ddy[4], ddat[4];
    int sv[4], sx[4], sy[4], sd[4];
    int niv, nix, niy, nid;
    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int want(int x, int y);
        if (x > 0) return 1;
        if (x < 0) return 3;
        if (y > 0) return 0;
        if (y < 0) return 2;
        return 4;
    endfunction

    function automatic int toward0(int v);
        return (v > 0) ? v - 1 : (v < 0) ? v + 1 : v;
    endfunction

    function automatic string tag_of(int o);
        if (o == 1 || o == 3) return "R4";
        if (o == 0 || o == 2) return "R5";
        return "R6";
    endfunction

    task automatic clear_stage();
        for (int c = 0; c < 4; c++) begin
            nv[c] = 0; nx[c] = 0; ny[c] = 0; nd[c] = 0;
        end
        niv = 0; nix = 0; niy = 0; nid = 0;
    endtask

    task automatic model_cmp();
        int ev[5], ex[5], ey[5], ed[5];
        int ord[4];
        bit eacc;
        eacc = 1'b0;
        for (int o = 0; o < 5; o++) begin
            ev[o] = 0; ex[o] = 0; ey[o] = 0; ed[o] = 0;
        end
        for (int o = 0; o < 5; o++) begin
            case (o)
                0: ord = '{2, 3, 1, 4};
                1: ord = '{3, 4, -1, -1};
                2: ord = '{0, 3, 1, 4};
                3: ord = '{1, 4, -1, -1};
                default: ord = '{0, 2, 3, 1};
            endcase
            for (int r = 0; r < 4; r++) begin
                int s, v, x, y, d;
                s = ord[r];
                if (s < 0 || ev[o] != 0) continue;
                if (s == 4) begin v = niv; x = nix; y = niy; d = nid; end
                else begin v = sv[s]; x = sx[s]; y = sy[s]; d = sd[s]; end
                if (v != 0 && want(x, y) == o) begin
                    ev[o] = 1;
                    ed[o] = d;
                    ex[o] = (o == 1 || o == 3) ? toward0(x) : x;
                    ey[o] = (o == 0 || o == 2) ? toward0(y) : y;
                    if (s == 4) eacc = 1'b1;
                end
            end
        end
        for (int o = 0; o < 4; o++) begin
            chk(link_out_vld[o] == ev[o][0], tag_of(o), $sformatf("out%0d valid", o),
                int'(link_out_vld[o]), ev[o]);
            if (ev[o] != 0) begin
                chk(int'($signed(link_out_dx[o])) == ex[o], "R3", $sformatf("out%0d dx", o),
                    int'($signed(link_out_dx[o])), ex[o]);
                chk(int'($signed(link_out_dy[o])) == ey[o], "R3", $sformatf("out%0d dy", o),
                    int'($signed(link_out_dy[o])), ey[o]);
                chk(int'(link_out_data[o]) == ed[o], tag_of(o), $sformatf("out%0d data", o),
                    int'(link_out_data[o]), ed[o]);
            end
        end
        chk(ej_vld == ev[4][0], "R6", "eject valid", int'(ej_vld), ev[4]);
        if (ev[4] != 0)
            chk(int'(ej_data) == ed[4], "R6", "eject data", int'(ej_data), ed[4]);
        chk(inj_accept == eacc, "R8", "inj_accept", int'(inj_accept), int'(eacc));
    endtask

    task automatic cycle();
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            if (rst_n) begin sv[c] = dv[c]; sx[c] = ddx[c]; sy[c] = ddy[c]; sd[c] = ddat[c]; end
            else       begin sv[c] = 0; sx[c] = 0; sy[c] = 0; sd[c] = 0; end
        end
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            dv[c] = nv[c]; ddx[c] = nx[c]; ddy[c] = ny[c]; ddat[c] = nd[c];
            link_in_vld[c]  = nv[c][0];
            link_in_dx[c]   = nx[c][CW-1:0];
            link_in_dy[c]   = ny[c][CW-1:0];
            link_in_data[c] = nd[c][DW-1:0];
        end
        inj_vld  = niv[0];
        inj_dx   = nix[CW-1:0];
        inj_dy   = niy[CW-1:0];
        inj_data = nid[DW-1:0];
        #1;
        model_cmp();
    endtask

    function automatic int rsmall();
        return int'($urandom_range(0, 3));
    endfunction

    task automatic random_stage();
        for (int c = 0; c < 4; c++) begin
            nv[c] = ($urandom_range(0, 9) < 6) ? 1 : 0;
            nd[c] = int'($urandom_range(0, 16'hFFFF));
            case (c)
                0: begin nx[c] = 0; ny[c] = -rsmall(); end
                2: begin nx[c] = 0; ny[c] = rsmall(); end
                3: begin nx[c] = rsmall(); ny[c] = int'($urandom_range(0, 6)) - 3; end
                default: begin nx[c] = -rsmall(); ny[c] = int'($urandom_range(0, 6)) - 3; end
            endcase
        end
        niv = ($urandom_range(0, 9) < 6) ? 1 : 0;
        nid = int'($urandom_range(0, 16'hFFFF));
        do begin
            nix = int'($urandom_range(0, 6)) - 3;
            niy = int'($urandom_range(0, 6)) - 3;
        end while (nix == 0 && niy == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_stage();
        for (int c = 0; c < 4; c++) begin dv[c] = 0; ddx[c] = 0; ddy[c] = 0; ddat[c] = 0; end
        link_in_vld = '0; link_in_dx = '0; link_in_dy = '0; link_in_data = '0;
        inj_vld = 1'b0; inj_dx = '0; inj_dy = '0; inj_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(link_out_vld == 4'b0, "R9", "link_out_vld after reset", int'(link_out_vld), 0);
        chk(ej_vld == 1'b0, "R9", "ej_vld after reset", int'(ej_vld), 0);
        chk(inj_accept == 1'b0, "R9", "inj_accept after reset", int'(inj_accept), 0);

        // R1 / R4: a west flit is not visible until registered; injection wins east meanwhile
        clear_stage();
        nv[3] = 1; nx[3] = 2; ny[3] = 1; nd[3] = 16'h1111;
        niv = 1; nix = 1; niy = 0; nid = 16'h2222;
        cycle();
        chk(int'(link_out_data[1]) == 16'h2222, "R1", "east data before capture",
            int'(link_out_data[1]), 16'h2222);
        nv[3] = 0;
        cycle();
        chk(int'(link_out_data[1]) == 16'h1111, "R4", "east data opposing wins",
            int'(link_out_data[1]), 16'h1111);
        chk(inj_accept == 1'b0, "R4", "injection loses east", int'(inj_accept), 0);
        // R7: the dropped injection and the forwarded flit do not reappear
        niv = 0;
        cycle();
        chk(link_out_vld == 4'b0 && !ej_vld, "R7", "nothing after drop",
            int'({ej_vld, link_out_vld}), 0);

        // R5: south straight beats west and east turns and injection for north
        clear_stage();
        nv[2] = 1; ny[2] = 2; nd[2] = 16'hA0A0;
        nv[3] = 1; ny[3] = 1; nd[3] = 16'hB0B0;
        nv[1] = 1; ny[1] = 3; nd[1] = 16'hC0C0;
        cycle();
        clear_stage();
        niv = 1; niy = 1; nid = 16'hD0D0;
        nv[3] = 1; ny[3] = 1; nd[3] = 16'hB1B1;
        nv[1] = 1; ny[1] = 1; nd[1] = 16'hC1C1;
        cycle();
        chk(int'(link_out_data[0]) == 16'hA0A0, "R5", "north picks straight",
            int'(link_out_data[0]), 16'hA0A0);
        chk(int'($signed(link_out_dy[0])) == 1, "R3", "north dy stepped",
            int'($signed(link_out_dy[0])), 1);
        clear_stage();
        niv = 1; niy = 1; nid = 16'hD0D0;
        cycle();
        chk(int'(link_out_data[0]) == 16'hB1B1, "R5", "north picks west turn",
            int'(link_out_data[0]), 16'hB1B1);

        // R6: all four ejecting, north wins
        clear_stage();
        for (int c = 0; c < 4; c++) begin nv[c] = 1; nd[c] = 16'h0E00 + c; end
        cycle();
        clear_stage();
        cycle();
        chk(int'(ej_data) == 16'h0E00, "R6", "eject order north first", int'(ej_data), 16'h0E00);

        // R8: injection with zero counts is never accepted or ejected
        clear_stage();
        niv = 1; nid = 16'h5555;
        cycle();
        chk(!inj_accept && !ej_vld, "R8", "zero-count injection",
            int'({inj_accept, ej_vld}), 0);

        // R2: injected westward and southward flits
        clear_stage();
        niv = 1; nix = -1; niy = 2; nid = 16'h7777;
        cycle();
        chk(link_out_vld == 4'b1000, "R2", "negative X goes west", int'(link_out_vld), 8);
        clear_stage();
        niv = 1; nix = 0; niy = -2; nid = 16'h6666;
        cycle();
        chk(link_out_vld == 4'b0100 && int'($signed(link_out_dy[2])) == -1, "R2",
            "negative Y goes south", int'(link_out_vld), 4);

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            random_stage();
            cycle();
        end

        // R9: reset mid-run clears the registers
        clear_stage();
        cycle();
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            link_in_vld[c] = 1'b1; link_in_dx[c] = '0; link_in_dy[c] = '0;
        end
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        link_in_vld = '0;
        rst_n = 1'b1;
        #1;
        chk(link_out_vld == 4'b0 && !ej_vld, "R9", "outputs after mid-run reset",
            int'({ej_vld, link_out_vld}), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule